// File: doc/BRIEF.md
# Update-Based Snooping Coherence Controller

This block sits beside one private write-back cache in a bus-based shared-memory system. It keeps a small direct-mapped array of multi-word lines coherent with peer caches through an update protocol. A write to a line that other caches may also hold is not handled by invalidating those copies. Instead, the written word goes out on the bus and every peer holding the line patches its own copy.

A resident line is in one of four states:

- Exclusive-clean: the only cached copy, and memory agrees with it.
- Shared-clean: a copy that other caches may also hold, and this cache does not own it.
- Shared-modified: a shared copy that this cache owns and must eventually write back. At most one cache holds a line in this state.
- Modified: the only cached copy, and it is dirty.

A line that is not in the array is simply not present. There is no invalid state for resident lines.

The controller has three ports:

- The processor port takes word reads and writes and holds the processor until each one completes.
- The bus master port issues line reads, one-word updates and line write-backs. Each transaction is presented in the cycle it is granted. The wired-OR shared signal and the fill data are sampled in the cycle after that.
- The snoop port receives the other caches' transactions. One cycle later it answers with a shared indication and, where the line is dirty here, a flush of the whole line.

Top module: `upd_snoop_ctrl`

## Requirements
- R1: After reset no line is present, so the first access to any address issues a bus read (command code 1) of its line, with the word offset bits of the bus address zero.
- R2: A read that hits completes in the cycle it is presented, with no bus transaction, and returns the newest word held for that address.
- R3: A read miss installs the line delivered in the response cycle, returns the requested word in that cycle, and leaves the line Shared-clean if the shared signal was high in the response cycle and Exclusive-clean otherwise.
- R4: A write hit on a Modified line completes in the cycle it is presented, with no bus traffic. A write hit on an Exclusive-clean line does the same and leaves the line Modified.
- R5: A write hit on a Shared-clean or Shared-modified line stalls the processor and issues an update (command code 2) that carries the full word address and the data word. The write completes in that update's response cycle. The line ends Shared-modified if the shared signal was high, and Modified otherwise.
- R6: A write miss issues a bus read followed by an update. The final state is set by the shared signal of the update: Shared-modified if high, Modified if low.
- R7: A snooped read (code 1) of a Modified or Shared-modified line raises the shared output and the flush output in the next cycle, with the whole line on the flush data, and leaves the line Shared-modified.
- R8: A snooped read of an Exclusive-clean or Shared-clean line raises only the shared output in the next cycle, and leaves the line Shared-clean.
- R9: A snooped update (code 2) of a resident line writes the carried word into it, raises the shared output in the next cycle, and leaves the line Shared-clean.
- R10: A snooped write-back (code 3), or any snoop of an absent line, raises neither output and changes nothing.
- R11: A miss whose direct-mapped slot holds a Modified or Shared-modified line first issues a write-back (code 3) of that whole line at its own line address, then the read. A clean occupant is dropped with no write-back.
- R12: In a cycle with a snoop presented, no processor access completes. A stalled hit completes once the snoop port is idle.
- R13: A transaction is presented in the cycle where request and grant are both high. The bus never presents a snoop in that cycle or in the response cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read data, valid with ready |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 1 read, 2 update, 3 write-back |
| bus_addr | output | AW | Word address (line base for read and write-back) |
| bus_wword | output | DW | Update data word |
| bus_wline | output | DW*WORDS | Write-back line data |
| bus_gnt | input | 1 | Grant; the transaction is on the bus this cycle |
| bus_shared | input | 1 | Wired-OR shared signal, response cycle |
| bus_rline | input | DW*WORDS | Fill line, response cycle |
| snp_valid | input | 1 | A peer transaction is presented |
| snp_cmd | input | 2 | Peer command code |
| snp_addr | input | AW | Peer word address |
| snp_wword | input | DW | Peer update word |
| snp_shared | output | 1 | This cache holds the snooped line (next cycle) |
| snp_flush | output | 1 | This cache supplies the line (next cycle) |
| snp_line | output | DW*WORDS | Flushed line data |

## Verification
The assertions check the following on every cycle:

- Each shared or flush response traces back to a snoop of the right kind in the cycle before.
- No processor access completes while a snoop is presented.
- A granted update completes the stalled write in its response cycle.
- A write-back is always followed by the read of the new line.
- The bus keeps the granted cycle and the response cycle free of snoops.

The state of a line cannot be seen directly, so only the bench's scenarios can show the state transitions. The bench infers the state from what the line does next:

- whether a following write stays silent or issues an update;
- whether a following snooped read brings a flush;
- whether a following miss writes the line back.

The bench also checks the data patched in by snooped updates through reads.

// File: rtl/upd_snoop_ctrl.sv
module upd_snoop_ctrl #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LINES = 8,
  parameter int WORDS = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic                cpu_ready,
  output logic [DW-1:0]       cpu_rdata,
  output logic                bus_req,
  output logic [1:0]          bus_cmd,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wword,
  output logic [DW*WORDS-1:0] bus_wline,
  input  logic                bus_gnt,
  input  logic                bus_shared,
  input  logic [DW*WORDS-1:0] bus_rline,
  input  logic                snp_valid,
  input  logic [1:0]          snp_cmd,
  input  logic [AW-1:0]       snp_addr,
  input  logic [DW-1:0]       snp_wword,
  output logic                snp_shared,
  output logic                snp_flush,
  output logic [DW*WORDS-1:0] snp_line
);
  localparam int OW = $clog2(WORDS);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - OW - IW;
  localparam int LW = DW * WORDS;

  localparam logic [1:0] C_RD = 2'd1, C_UPD = 2'd2, C_WB = 2'd3;
  localparam logic [2:0] S_NP = 3'd0, S_E = 3'd1, S_SC = 3'd2, S_SM = 3'd3, S_M = 3'd4;
  localparam logic [1:0] P_IDLE = 2'd0, P_MISS = 2'd1, P_UPD = 2'd2, P_RESP = 2'd3;

  logic [LW-1:0] line_q [LINES];
  logic [TW-1:0] tag_q  [LINES];
  logic [2:0]    st_q   [LINES];

  logic [1:0]    p_st, cur_cmd;
  logic [AW-1:0] r_addr;
  logic          r_we;
  logic [DW-1:0] r_wdata;

  wire [IW-1:0] c_idx = cpu_addr[OW +: IW];
  wire [TW-1:0] c_tag = cpu_addr[AW-1 -: TW];
  wire [OW-1:0] c_off = cpu_addr[OW-1:0];
  wire [IW-1:0] r_idx = r_addr[OW +: IW];
  wire [TW-1:0] r_tag = r_addr[AW-1 -: TW];
  wire [OW-1:0] r_off = r_addr[OW-1:0];
  wire [IW-1:0] s_idx = snp_addr[OW +: IW];
  wire [TW-1:0] s_tag = snp_addr[AW-1 -: TW];
  wire [OW-1:0] s_off = snp_addr[OW-1:0];

  wire [2:0] c_st = st_q[c_idx];
  wire [2:0] s_st = st_q[s_idx];
  wire [2:0] v_st = st_q[r_idx];

  wire c_hit   = (c_st != S_NP) && (tag_q[c_idx] == c_tag);
  wire c_own   = (c_st == S_E) || (c_st == S_M);
  wire s_hit   = snp_valid && (s_st != S_NP) && (tag_q[s_idx] == s_tag);
  wire s_dirty = (s_st == S_M) || (s_st == S_SM);
  wire v_dirty = (v_st == S_M) || (v_st == S_SM);

  wire idle_go   = (p_st == P_IDLE) && cpu_req && !snp_valid;
  wire hit_done  = idle_go && c_hit && (!cpu_we || c_own);
  wire resp_done = (p_st == P_RESP) && ((cur_cmd == C_UPD) || (cur_cmd == C_RD && !r_we));
  wire granted   = bus_req && bus_gnt;

  assign cpu_ready = hit_done || resp_done;
  assign cpu_rdata = (p_st == P_RESP) ? bus_rline[r_off*DW +: DW]
                                      : line_q[c_idx][c_off*DW +: DW];

  assign bus_req   = (p_st == P_MISS) || (p_st == P_UPD);
  assign bus_cmd   = !bus_req ? 2'd0 : (p_st == P_UPD) ? C_UPD : (v_dirty ? C_WB : C_RD);
  assign bus_addr  = (p_st == P_UPD) ? r_addr
                   : v_dirty ? {tag_q[r_idx], r_idx, {OW{1'b0}}}
                             : {r_tag, r_idx, {OW{1'b0}}};
  assign bus_wword = r_wdata;
  assign bus_wline = line_q[r_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_st    <= P_IDLE;
      cur_cmd <= 2'd0;
      r_addr  <= '0;
      r_we    <= 1'b0;
      r_wdata <= '0;
    end else begin
      case (p_st)
        P_IDLE: if (idle_go && (!c_hit || (cpu_we && !c_own))) begin
          r_addr  <= cpu_addr;
          r_we    <= cpu_we;
          r_wdata <= cpu_wdata;
          p_st    <= c_hit ? P_UPD : P_MISS;
        end
        P_MISS, P_UPD: if (bus_gnt) begin
          cur_cmd <= bus_cmd;
          p_st    <= P_RESP;
        end
        default: begin
          case (cur_cmd)
            C_WB:    p_st <= P_MISS;
            C_RD:    p_st <= r_we ? P_UPD : P_IDLE;
            default: p_st <= P_IDLE;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= S_NP;
    end else begin
      if (s_hit) begin
        if (snp_cmd == C_UPD) st_q[s_idx] <= S_SC;
        else if (snp_cmd == C_RD) st_q[s_idx] <= s_dirty ? S_SM : S_SC;
      end
      if (hit_done && cpu_we) st_q[c_idx] <= S_M;
      if (p_st == P_RESP) begin
        case (cur_cmd)
          C_WB:    st_q[r_idx] <= S_NP;
          C_RD:    st_q[r_idx] <= bus_shared ? S_SC : S_E;
          default: st_q[r_idx] <= bus_shared ? S_SM : S_M;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (s_hit && snp_cmd == C_UPD) line_q[s_idx][s_off*DW +: DW] <= snp_wword;
    if (hit_done && cpu_we) line_q[c_idx][c_off*DW +: DW] <= cpu_wdata;
    if (p_st == P_RESP && cur_cmd == C_RD) begin
      line_q[r_idx] <= bus_rline;
      tag_q[r_idx]  <= r_tag;
    end
    if (p_st == P_RESP && cur_cmd == C_UPD) line_q[r_idx][r_off*DW +: DW] <= r_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snp_shared <= 1'b0;
      snp_flush  <= 1'b0;
      snp_line   <= '0;
    end else begin
      snp_shared <= s_hit && (snp_cmd == C_RD || snp_cmd == C_UPD);
      snp_flush  <= s_hit && (snp_cmd == C_RD) && s_dirty;
      snp_line   <= line_q[s_idx];
    end
  end

  // R13
  bus_slot_chk: assert property (@(posedge clk) disable iff (!rst_n) granted |-> !snp_valid);
  // R13
  resp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n) granted |=> !snp_valid);
  // R12
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n) snp_valid |-> !cpu_ready);
  // R7
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> ($past(snp_valid) && $past(snp_cmd) == C_RD && snp_shared));
  // R10
  shared_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> ($past(snp_valid) && $past(snp_cmd) != C_WB));
  // R5
  upd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && bus_cmd == C_UPD) |=> cpu_ready);
  // R11
  wb_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && bus_cmd == C_WB) |=> ##1 (bus_req && bus_cmd == C_RD));
endmodule

// File: tb/upd_snoop_ctrl_bench.sv
module upd_snoop_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int AW = 16, DW = 32, LINES = 8, WORDS = 4, LW = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wword;
  logic [LW-1:0] bus_wline;
  logic bus_gnt = 0, bus_shared = 0;
  logic [LW-1:0] bus_rline = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_wword = '0;
  logic snp_shared, snp_flush;
  logic [LW-1:0] snp_line;

  always #(CLK_NS/2) clk = ~clk;

  upd_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(LINES), .WORDS(WORDS)) u_upd_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wword(bus_wword),
    .bus_wline(bus_wline), .bus_gnt(bus_gnt), .bus_shared(bus_shared), .bus_rline(bus_rline),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wword(snp_wword),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_line(snp_line));

  int nchk = 0, nfail = 0;
  logic [DW-1:0] mem_w [128];
  int m_st [LINES];
  logic [10:0] m_tag [LINES];
  logic [LW-1:0] m_line [LINES];
  logic [1:0] lg_cmd [4];
  logic [AW-1:0] lg_addr [4];
  logic [DW-1:0] lg_word [4];
  logic [LW-1:0] lg_line [4];
  int nlog;
  logic [1:0] ex_cmd [4];
  logic [AW-1:0] ex_addr [4];
  logic [DW-1:0] ex_word [4];
  logic [LW-1:0] ex_line [4];
  int nex;

  task automatic chk(input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tg, input int ix, input int of);
    return AW'((tg << 5) | (ix << 2) | of);
  endfunction

  function automatic logic [LW-1:0] memline(input logic [AW-1:0] a);
    logic [LW-1:0] l;
    for (int k = 0; k < WORDS; k++) l[k*DW +: DW] = mem_w[{a[6:2], 2'b00} + k];
    return l;
  endfunction

  function automatic void push(input logic [1:0] c, input logic [AW-1:0] a,
                               input logic [DW-1:0] w, input logic [LW-1:0] l);
    ex_cmd[nex] = c; ex_addr[nex] = a; ex_word[nex] = w; ex_line[nex] = l;
    nex++;
  endfunction

  task automatic run_cpu(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic shrd, input logic shupd, output logic [DW-1:0] rd);
    int cyc = 0;
    logic due = 0, dsh = 0, fin = 0;
    logic [LW-1:0] dline = '0;
    nlog = 0; rd = '0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    while (!fin) begin
      #1;
      if (cpu_ready) begin
        rd = cpu_rdata; fin = 1;
      end else begin
        if (bus_req && nlog < 4) begin
          bus_gnt = 1;
          lg_cmd[nlog] = bus_cmd; lg_addr[nlog] = bus_addr;
          lg_word[nlog] = bus_wword; lg_line[nlog] = bus_wline;
          nlog++;
          dsh = (bus_cmd == 2'd1) ? shrd : (bus_cmd == 2'd2) ? shupd : 1'b0;
          dline = memline(bus_addr);
          if (bus_cmd == 2'd3)
            for (int k = 0; k < WORDS; k++) mem_w[{bus_addr[6:2], 2'b00} + k] = bus_wline[k*DW +: DW];
          due = 1;
        end
        @(negedge clk);
        bus_gnt = 0;
        bus_shared = due ? dsh : 1'b0;
        bus_rline = due ? dline : '0;
        due = 0;
        cyc++;
        if (cyc > 40) begin
          fin = 1;
          chk("R5 completion", 0, 1);
        end
      end
    end
    @(negedge clk);
    cpu_req = 0; bus_shared = 0; bus_rline = '0;
  endtask

  task automatic do_cpu(input string rq, input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic shrd, input logic shupd);
    int ix = int'(a[4:2]);
    logic [10:0] tg = a[15:5];
    int of = int'(a[1:0]);
    logic hit = (m_st[ix] != 0) && (m_tag[ix] == tg);
    logic [DW-1:0] erd = '0, rd;
    logic [LW-1:0] fl;
    nex = 0;
    if (!hit) begin
      if (m_st[ix] == 3 || m_st[ix] == 4) push(2'd3, {m_tag[ix], 3'(ix), 2'b00}, d, m_line[ix]);
      push(2'd1, {tg, 3'(ix), 2'b00}, d, '0);
      fl = memline(a);
      m_line[ix] = fl; m_tag[ix] = tg; m_st[ix] = shrd ? 2 : 1;
      erd = fl[of*DW +: DW];
    end else erd = m_line[ix][of*DW +: DW];
    if (we) begin
      if (hit && (m_st[ix] == 1 || m_st[ix] == 4)) m_st[ix] = 4;
      else begin
        push(2'd2, a, d, '0);
        m_st[ix] = shupd ? 3 : 4;
      end
      m_line[ix][of*DW +: DW] = d;
    end
    run_cpu(we, a, d, shrd, shupd, rd);
    chk({rq, " bus count"}, LW'(nlog), LW'(nex));
    for (int i = 0; i < nex && i < nlog; i++) begin
      chk({rq, " bus cmd"}, LW'(lg_cmd[i]), LW'(ex_cmd[i]));
      chk({rq, " bus addr"}, LW'(lg_addr[i]), LW'(ex_addr[i]));
      if (ex_cmd[i] == 2'd2) chk({rq, " update word"}, LW'(lg_word[i]), LW'(ex_word[i]));
      if (ex_cmd[i] == 2'd3) chk({rq, " writeback line"}, lg_line[i], ex_line[i]);
    end
    if (!we) chk({rq, " read data"}, LW'(rd), LW'(erd));
  endtask

  task automatic do_snp(input string rq, input logic [1:0] c, input logic [AW-1:0] a,
                        input logic [DW-1:0] w);
    int ix = int'(a[4:2]);
    int of = int'(a[1:0]);
    logic hit = (m_st[ix] != 0) && (m_tag[ix] == a[15:5]);
    logic esh = 0, efl = 0;
    logic [LW-1:0] eln = m_line[ix];
    if (hit && c == 2'd1) begin
      esh = 1;
      efl = (m_st[ix] == 3 || m_st[ix] == 4);
      m_st[ix] = efl ? 3 : 2;
    end else if (hit && c == 2'd2) begin
      esh = 1;
      m_st[ix] = 2;
      m_line[ix][of*DW +: DW] = w;
    end
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_wword = w;
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk({rq, " snoop shared"}, LW'(snp_shared), LW'(esh));
    chk({rq, " snoop flush"}, LW'(snp_flush), LW'(efl));
    if (efl) chk({rq, " snoop line"}, snp_line, eln);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [DW-1:0] tmp;
    tmp = $urandom(32'd4242);
    for (int i = 0; i < 128; i++) mem_w[i] = $urandom;
    for (int i = 0; i < LINES; i++) begin
      m_st[i] = 0; m_tag[i] = '0; m_line[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset bus_req", LW'(bus_req), 0);
    chk("R1 reset ready", LW'(cpu_ready), 0);
    chk("R1 reset snoop", LW'({snp_shared, snp_flush}), 0);

    do_cpu("R1 R3 first read exclusive", 0, mk(0,1,2), 0, 0, 0);
    do_cpu("R2 read hit", 0, mk(0,1,0), 0, 0, 0);
    do_cpu("R4 write on exclusive", 1, mk(0,1,1), 32'h1111_0001, 0, 0);
    chk("R4 silent write", LW'(nlog), 0);
    do_cpu("R4 write on modified", 1, mk(0,1,3), 32'h1111_0003, 0, 0);
    do_snp("R7 flush from modified", 2'd1, mk(0,1,0), 0);
    do_cpu("R5 write on shared-modified", 1, mk(0,1,1), 32'h2222_0001, 0, 1);
    chk("R5 update issued", LW'(nlog), 1);
    do_snp("R9 peer update", 2'd2, mk(0,1,3), 32'h3333_0003);
    do_cpu("R9 patched word read", 0, mk(0,1,3), 0, 0, 0);
    do_cpu("R5 write shared-clean alone", 1, mk(0,1,2), 32'h4444_0002, 0, 0);
    do_snp("R7 flush after update alone", 2'd1, mk(0,1,2), 0);
    do_cpu("R11 dirty victim writeback", 0, mk(2,1,1), 0, 1, 0);
    chk("R11 two transactions", LW'(nlog), 2);
    do_snp("R10 snooped writeback", 2'd3, mk(2,1,0), 0);
    do_snp("R10 absent line", 2'd1, mk(5,6,0), 0);
    do_cpu("R6 write miss", 1, mk(1,3,2), 32'h5555_0002, 1, 0);
    do_snp("R6 ends modified", 2'd1, mk(1,3,0), 0);
    do_cpu("R6 write miss shared", 1, mk(1,4,0), 32'h5555_0100, 0, 1);
    do_cpu("R11 clean victim dropped", 0, mk(0,1,0), 0, 0, 0);
    chk("R11 no writeback", LW'(nlog), 1);
    do_cpu("R3 read miss shared", 0, mk(2,5,3), 0, 1, 0);
    do_cpu("R3 shared-clean write updates", 1, mk(2,5,3), 32'h6666_0003, 0, 1);
    do_cpu("R8 exclusive fill", 0, mk(0,6,1), 0, 0, 0);
    do_snp("R8 snoop exclusive", 2'd1, mk(0,6,1), 0);
    do_cpu("R8 now shared-clean", 1, mk(0,6,1), 32'h7777_0001, 0, 0);
    chk("R8 update after snoop", LW'(nlog), 1);

    // R12: snoop and processor hit in the same cycle
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = mk(0,6,1);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = mk(7,7,0);
    #1;
    chk("R12 stalled by snoop", LW'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R12 resumes", LW'(cpu_ready), 1);
    chk("R12 data", LW'(cpu_rdata), LW'(m_line[6][DW +: DW]));
    @(negedge clk);
    cpu_req = 0;

    for (int n = 0; n < 400; n++) begin
      int kind = int'($urandom % 5);
      logic [AW-1:0] a = mk(int'($urandom % 3), int'($urandom % 3), int'($urandom % 4));
      logic [DW-1:0] w = $urandom;
      logic s1 = 1'($urandom), s2 = 1'($urandom);
      case (kind)
        0, 1: do_cpu("R2 R3 R11 random read", 0, a, 0, s1, s2);
        2:    do_cpu("R4 R5 R6 random write", 1, a, w, s1, s2);
        3:    do_snp("R7 R8 R10 random snoop read", 2'(1 + ($urandom % 3 == 0 ? 2 : 0)), a, w);
        default: do_snp("R9 random snoop update", 2'd2, a, w);
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule